// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast-Interrupt Routing

The controller gathers up to thirty interrupt requests and turns them into two request lines for a processor: a normal interrupt line with a source-number vector, and a fast-interrupt line for urgent work. The default layout puts eight external pins at the low source numbers (0 to 7). The remaining twenty-two inputs come from on-chip peripherals: watchdog, timers, serial ports, DMA channels, real-time clock, converter and the two serial buses. These take source numbers 8 to 29.

Each external pin passes through a two-flop synchronizer. Software chooses per pin whether it is level-sensed or edge-latched, and whether the active sense is high/rising or low/falling. Peripheral requests are synchronous and always latch. Each source has its own enable bit and a route bit that selects the normal or the fast line. A single mask bit silences both lines. The vector names the lowest-numbered enabled source pending on the normal line. This lets the handler branch straight to its service routine without scanning. Software configures the block through a small word-addressed register bus whose data width equals the source count. Reads are combinational and writes take effect at the clock edge.

Top module: `intc_top`

## Requirements
- R1: After reset the enable, route, trigger and polarity registers read 0, the control register reads 1 (masked), pending reads 0, and irqOut, fiqOut and irqVector are 0.
- R2: Register offsets are 0 enable, 1 route (1 = fast line), 2 pending, 3 trigger (external bits only, 1 = edge), 4 polarity (external bits only, 1 = low/falling), 5 control (bit 0 = mask). Unused upper bits and unmapped offsets read 0, and read data is valid in the same cycle as the read select.
- R3: A peripheral request high at a clock edge sets its pending bit (source = 8 + request index). The bit stays set until a write to offset 2 with a 1 in that position. A set in the same cycle as the clear wins.
- R4: An external pin in level mode shows its synchronized active level in the pending register (high-active when its polarity bit is 0, low-active when 1). Writing 1 to its pending bit has no effect.
- R5: An external pin in edge mode latches a pending bit on a rising edge (polarity 0) or a falling edge (polarity 1) seen after synchronization. The bit holds until cleared by a write of 1, and the opposite edge does not set it.
- R6: irqOut is high exactly when some enabled pending source has route 0 and the mask is 0.
- R7: fiqOut is high exactly when some enabled pending source has route 1 and the mask is 0.
- R8: irqVector holds the lowest source number that is enabled, pending and routed to the normal line, or 0 when there is none. Sources routed to the fast line do not affect it.
- R9: With the mask set, irqOut and fiqOut are both low while pending bits keep collecting requests, which assert once the mask clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extIn | input | 8 | Asynchronous external interrupt pins (sources 0..7) |
| periphReq | input | 22 | Synchronous peripheral requests (sources 8..29) |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word offset of the register |
| busWData | input | 30 | Write data |
| busRData | output | 30 | Read data, combinational |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |
| irqVector | output | 5 | Source number of the winning normal-line source |

## Verification
The checks assume that peripheral requests are synchronous to clk. They also assume that the bus holds select, write and address stable for a whole cycle, and that no clear write overlaps a request unless that overlap is the subject of the test. The bench changes every input just after the falling edge. It holds external pin levels for at least four cycles, so each edge reaches the detector cleanly through the synchronizer. It samples the outputs and read data before the next rising edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_ROUTE  = 3'd1,
    SEL_PEND   = 3'd2,
    SEL_TRIG   = 3'd3,
    SEL_POL    = 3'd4,
    SEL_CTRL   = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } regsel_t;

  typedef struct packed {
    logic    wrEnable;
    logic    wrRoute;
    logic    wrClear;
    logic    wrTrig;
    logic    wrPol;
    logic    wrCtrl;
    regsel_t rdSel;
  } strobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 30,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               busSel,
  input  logic               busWr,
  input  logic [2:0]         busAddr,
  input  logic [NUM_SRC-1:0] irqAct,
  input  logic [NUM_SRC-1:0] fiqAct,
  input  logic               maskQ,
  output strobe_t            strb,
  output logic               irqOut,
  output logic               fiqOut,
  output logic [VEC_W-1:0]   irqVector
);
  regsel_t sel;

  always_comb begin
    sel = regsel_t'(busAddr);
    strb = '0;
    strb.rdSel = sel;
    if (busSel && busWr) begin
      unique case (sel)
        SEL_ENABLE: strb.wrEnable = 1'b1;
        SEL_ROUTE:  strb.wrRoute  = 1'b1;
        SEL_PEND:   strb.wrClear  = 1'b1;
        SEL_TRIG:   strb.wrTrig   = 1'b1;
        SEL_POL:    strb.wrPol    = 1'b1;
        SEL_CTRL:   strb.wrCtrl   = 1'b1;
        default:    ;
      endcase
    end
  end

  // lowest source number wins: scan from the top down so the last hit sticks
  always_comb begin
    irqVector = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (irqAct[i]) irqVector = VEC_W'(i);
    end
  end

  assign irqOut = !maskQ && (|irqAct);
  assign fiqOut = !maskQ && (|fiqAct);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 30,
  parameter int NUM_EXT = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extIn,
  input  logic [NUM_SRC-NUM_EXT-1:0] periphReq,
  input  strobe_t                    strb,
  input  logic [NUM_SRC-1:0]         wData,
  output logic [NUM_SRC-1:0]         rData,
  output logic [NUM_SRC-1:0]         irqAct,
  output logic [NUM_SRC-1:0]         fiqAct,
  output logic                       maskQ,
  output logic [NUM_SRC-1:0]         latchQ
);
  localparam int NUM_INT = NUM_SRC - NUM_EXT;

  logic [NUM_SRC-1:0] enableQ, routeQ, setVec, pendView, clrVec;
  logic [NUM_EXT-1:0] trigQ, polQ, syncA, syncB, prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      routeQ  <= '0;
      trigQ   <= '0;
      polQ    <= '0;
      maskQ   <= 1'b1;
    end else begin
      if (strb.wrEnable) enableQ <= wData;
      if (strb.wrRoute)  routeQ  <= wData;
      if (strb.wrTrig)   trigQ   <= wData[NUM_EXT-1:0];
      if (strb.wrPol)    polQ    <= wData[NUM_EXT-1:0];
      if (strb.wrCtrl)   maskQ   <= wData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= extIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic riseHit, fallHit;
    assign riseHit     = syncB[e] && !prevQ[e];
    assign fallHit     = !syncB[e] && prevQ[e];
    assign setVec[e]   = trigQ[e] && (polQ[e] ? fallHit : riseHit);
    assign pendView[e] = trigQ[e] ? latchQ[e] : (syncB[e] ^ polQ[e]);
  end

  for (genvar k = 0; k < NUM_INT; k++) begin : g_int
    assign setVec[NUM_EXT+k]   = periphReq[k];
    assign pendView[NUM_EXT+k] = latchQ[NUM_EXT+k];
  end

  assign clrVec = strb.wrClear ? wData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else       latchQ <= (latchQ & ~clrVec) | setVec;
  end

  assign irqAct = pendView & enableQ & ~routeQ;
  assign fiqAct = pendView & enableQ & routeQ;

  always_comb begin
    unique case (strb.rdSel)
      SEL_ENABLE: rData = enableQ;
      SEL_ROUTE:  rData = routeQ;
      SEL_PEND:   rData = pendView;
      SEL_TRIG:   rData = NUM_SRC'(trigQ);
      SEL_POL:    rData = NUM_SRC'(polQ);
      SEL_CTRL:   rData = NUM_SRC'(maskQ);
      default:    rData = '0;
    endcase
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 30,
  parameter int NUM_EXT = 8,
  parameter int VEC_W   = $clog2(NUM_SRC)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extIn,
  input  logic [NUM_SRC-NUM_EXT-1:0] periphReq,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [2:0]                 busAddr,
  input  logic [NUM_SRC-1:0]         busWData,
  output logic [NUM_SRC-1:0]         busRData,
  output logic                       irqOut,
  output logic                       fiqOut,
  output logic [VEC_W-1:0]           irqVector
);
  strobe_t            strb;
  logic [NUM_SRC-1:0] irqAct, fiqAct, latchQ;
  logic               maskQ;

  intc_ctrl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .irqAct(irqAct), .fiqAct(fiqAct), .maskQ(maskQ),
    .strb(strb), .irqOut(irqOut), .fiqOut(fiqOut), .irqVector(irqVector)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC), .NUM_EXT(NUM_EXT)) u_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .periphReq(periphReq),
    .strb(strb), .wData(busWData), .rData(busRData),
    .irqAct(irqAct), .fiqAct(fiqAct), .maskQ(maskQ), .latchQ(latchQ)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int NUM_SRC = 30,
  parameter int VEC_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               irqOut,
  input logic               fiqOut,
  input logic [VEC_W-1:0]   irqVector,
  input logic [NUM_SRC-1:0] irqAct,
  input logic [NUM_SRC-1:0] fiqAct,
  input logic               maskQ,
  input logic [NUM_SRC-1:0] latchQ,
  input logic               clrWrite
);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    !clrWrite |=> ((latchQ & $past(latchQ)) == $past(latchQ)));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (!maskQ && irqAct[irqVector]));

  p_fiq_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (!maskQ && (fiqAct != '0)));

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((irqAct & ((NUM_SRC'(1) << irqVector) - NUM_SRC'(1))) == '0));

  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> (!irqOut && !fiqOut));
endmodule

bind intc_top intc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .fiqOut(fiqOut),
  .irqVector(irqVector), .irqAct(irqAct), .fiqAct(fiqAct),
  .maskQ(maskQ), .latchQ(latchQ), .clrWrite(strb.wrClear)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 30;
  localparam int NE = 8;
  localparam logic [NS-1:0] ALL = {NS{1'b1}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NE-1:0] extIn = '0;
  logic [NS-NE-1:0] periphReq = '0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [NS-1:0] busWData = '0;
  logic [NS-1:0] busRData;
  logic irqOut, fiqOut;
  logic [4:0] irqVector;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top dut (
    .clk(clk), .rstN(rstN), .extIn(extIn), .periphReq(periphReq),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWData(busWData),
    .busRData(busRData), .irqOut(irqOut), .fiqOut(fiqOut), .irqVector(irqVector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NS-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRData;
    busSel = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); periphReq[k] = 1'b1;
    @(negedge clk); periphReq[k] = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [NS-1:0] d;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d); chk("R1 reg", 32'(d), 0);
    end
    rd(3'd5, d); chk("R1 mask", 32'(d), 1);
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 fiqOut", 32'(fiqOut), 0);
    chk("R1 vector", 32'(irqVector), 0);
  endtask

  task automatic t_regs;
    logic [NS-1:0] d;
    wr(3'd0, ALL);          rd(3'd0, d); chk("R2 enable", 32'(d), 32'h3FFF_FFFF);
    wr(3'd1, 30'h0155_AAAA); rd(3'd1, d); chk("R2 route", 32'(d), 32'h0155_AAAA);
    wr(3'd3, ALL);          rd(3'd3, d); chk("R2 trig width", 32'(d), 32'hFF);
    wr(3'd4, 30'h5A);       rd(3'd4, d); chk("R2 polarity", 32'(d), 32'h5A);
    wr(3'd5, 30'h2);        rd(3'd5, d); chk("R2 ctrl upper bits", 32'(d), 0);
    wr(3'd6, ALL);          rd(3'd6, d); chk("R2 unmapped", 32'(d), 0);
    rd(3'd7, d); chk("R2 unmapped7", 32'(d), 0);
    wr(3'd0, '0); wr(3'd1, '0); wr(3'd3, '0); wr(3'd4, '0); wr(3'd5, 30'h1);
  endtask

  task automatic t_periph;
    logic [NS-1:0] d;
    pulse(2);
    rd(3'd2, d); chk("R3 latched", 32'(d), 32'h400);
    waitCyc(3);
    rd(3'd2, d); chk("R3 held", 32'(d), 32'h400);
    wr(3'd2, 30'h400);
    rd(3'd2, d); chk("R3 cleared", 32'(d), 0);
    @(negedge clk); periphReq[5] = 1'b1;
    wr(3'd2, 30'h2000);
    periphReq[5] = 1'b0;
    rd(3'd2, d); chk("R3 set beats clear", 32'(d), 32'h2000);
    wr(3'd2, 30'h2000);
    rd(3'd2, d); chk("R3 clear after", 32'(d), 0);
  endtask

  task automatic t_level;
    logic [NS-1:0] d;
    @(negedge clk); extIn[3] = 1'b1;
    waitCyc(3);
    rd(3'd2, d); chk("R4 high level", 32'(d), 32'h8);
    wr(3'd2, 30'h8);
    rd(3'd2, d); chk("R4 clear ignored", 32'(d), 32'h8);
    @(negedge clk); extIn[3] = 1'b0;
    waitCyc(3);
    rd(3'd2, d); chk("R4 level drop", 32'(d), 0);
    wr(3'd4, 30'h8);
    rd(3'd2, d); chk("R4 low-active", 32'(d), 32'h8);
    wr(3'd4, '0);
  endtask

  task automatic t_edge;
    logic [NS-1:0] d;
    wr(3'd3, 30'h20);
    @(negedge clk); extIn[5] = 1'b1;
    waitCyc(4);
    rd(3'd2, d); chk("R5 rising latch", 32'(d), 32'h20);
    @(negedge clk); extIn[5] = 1'b0;
    waitCyc(4);
    rd(3'd2, d); chk("R5 sticky", 32'(d), 32'h20);
    wr(3'd2, 30'h20);
    rd(3'd2, d); chk("R5 cleared", 32'(d), 0);
    wr(3'd4, 30'h20);
    @(negedge clk); extIn[5] = 1'b1;
    waitCyc(4);
    rd(3'd2, d); chk("R5 opposite edge ignored", 32'(d), 0);
    @(negedge clk); extIn[5] = 1'b0;
    waitCyc(4);
    rd(3'd2, d); chk("R5 falling latch", 32'(d), 32'h20);
    wr(3'd2, 30'h20);
    wr(3'd3, '0); wr(3'd4, '0);
  endtask

  task automatic t_outputs;
    logic [NS-1:0] d;
    wr(3'd0, ALL);
    wr(3'd5, '0);
    pulse(4); pulse(12);
    chk("R6 irq on", 32'(irqOut), 1);
    chk("R8 lowest 12", 32'(irqVector), 12);
    chk("R7 fiq off", 32'(fiqOut), 0);
    wr(3'd1, 30'h1000);
    chk("R7 fiq on", 32'(fiqOut), 1);
    chk("R8 fiq source skipped", 32'(irqVector), 20);
    wr(3'd2, 30'h10_0000);
    chk("R6 irq off", 32'(irqOut), 0);
    chk("R8 vector idle", 32'(irqVector), 0);
    wr(3'd5, 30'h1);
    chk("R9 irq masked", 32'(irqOut), 0);
    chk("R9 fiq masked", 32'(fiqOut), 0);
    pulse(7);
    rd(3'd2, d); chk("R9 pend while masked", 32'(d), 32'h9000);
    wr(3'd5, '0);
    chk("R9 irq after unmask", 32'(irqOut), 1);
    chk("R8 vector 15", 32'(irqVector), 15);
    @(negedge clk); extIn[1] = 1'b1;
    waitCyc(3);
    chk("R8 external wins", 32'(irqVector), 1);
    @(negedge clk); extIn[1] = 1'b0;
    waitCyc(3);
    wr(3'd0, ALL & ~30'h8000);
    chk("R6 disabled source", 32'(irqOut), 0);
    chk("R7 fiq still on", 32'(fiqOut), 1);
    wr(3'd2, ALL);
    chk("R7 fiq cleared", 32'(fiqOut), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    @(negedge clk) rstN = 1'b1;
    t_reset();
    t_regs();
    t_periph();
    t_level();
    t_edge();
    t_outputs();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule